// File: doc/BRIEF.md
# DMA Channel Trigger and Control Sequencer

This block is the control engine of a single DMA channel. It latches trigger events from a peripheral or from a software force and starts bursts of word transfers. It counts words within a burst and bursts within a transfer, and it decides what happens when a transfer finishes: the channel either stops, or reloads its counters and waits for the next trigger. Address generation and the memory accesses belong to a datapath outside this block. The datapath sees one word request at a time on a valid/ready pair. A word counts as done only on a cycle where `word_valid` and `word_ready` are both high. While `word_ready` is low, the sequencer keeps `word_valid` asserted. Back-pressure therefore only delays a burst and never loses a word.

Software-style control arrives as one-cycle strobes: run, halt, soft reset, force, clear flag and clear error. Mode levels select one-shot chaining, continuous restart, interrupt timing and the interrupt enables. The burst length and transfer length are given as "count minus one" and are sampled by the sequencer at the points where it loads them. All status outputs and the interrupt line come straight from flops.

Top module: `dma_chan_seq`

## Requirements
- R1: After `rst_n` low, or on the edge after a `soft_rst` strobe, `run_sts`, `burst_sts`, `xfer_sts`, `trig_flag`, `ovf_flag`, `ch_int` and `word_valid` are all 0.
- R2: A trigger event is `periph_trig` or `force_trig` high while `trig_en` is 1, and it sets `trig_flag`. While `trig_en` is 0, neither input changes `trig_flag`.
- R3: `trig_flag` clears when a burst launched by it starts, or on a `clr_trig` strobe. A trigger event in the same cycle keeps it set.
- R4: A trigger event while `trig_flag` is already set, and not being consumed by a burst start in that cycle, sets `ovf_flag`. `ovf_flag` then holds until a `clr_err` strobe.
- R5: With `oneshot` = 0, each consumed trigger produces exactly `burst_len`+1 word handshakes. After that the channel idles until the next trigger.
- R6: With `oneshot` = 1, one trigger produces all (`xfer_len`+1)·(`burst_len`+1) word handshakes of the transfer, with no further trigger.
- R7: When the last word of a transfer completes, `run_sts` clears if `contin` = 0. If `contin` = 1, `run_sts` stays 1, the transfer count reloads, and the next full transfer needs a new trigger.
- R8: `xfer_sts` is 1 from the start of a transfer's first burst until its last word completes. `burst_sts` is 1 from a burst start until that burst's last word. `burst_sts` implies `xfer_sts`.
- R9: When `int_en` = 1, `ch_int` pulses on the same edge that `xfer_sts` rises if `int_at_end` = 0, or on the same edge that `xfer_sts` falls if `int_at_end` = 1. When `int_en` = 0, no transfer interrupt is raised.
- R10: An overflow event pulses `ch_int` only when both `ovr_int_en` and `int_en` are 1.
- R11: A `halt` strobe clears `run_sts` once no word is waiting on `word_ready`. No further words are requested while halted. The counters and the transfer state are kept, and `run` resumes so that the total word count is unchanged.
- R12: Once `word_valid` is raised it stays high until `word_ready` is seen, unless `soft_rst` is asserted.
- R13: `run` with no transfer in progress loads the transfer count. Triggers while the channel is stopped only set `trig_flag` and request no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous channel reset strobe |
| run | input | 1 | Start or resume strobe |
| halt | input | 1 | Stop-after-current-word strobe |
| force_trig | input | 1 | Software trigger strobe |
| clr_trig | input | 1 | Clear trigger flag strobe |
| clr_err | input | 1 | Clear overflow flag strobe |
| periph_trig | input | 1 | Peripheral trigger pulse |
| trig_en | input | 1 | Enables both trigger sources |
| oneshot | input | 1 | Chain all bursts from one trigger |
| contin | input | 1 | Restart after each transfer |
| int_at_end | input | 1 | 1: interrupt at transfer end, 0: at start |
| int_en | input | 1 | Channel interrupt enable |
| ovr_int_en | input | 1 | Overflow interrupt enable |
| burst_len | input | BW | Words per burst minus one |
| xfer_len | input | TW | Bursts per transfer minus one |
| word_valid | output | 1 | Word transfer request to the datapath |
| word_ready | input | 1 | Datapath accepts and completes the word |
| run_sts | output | 1 | Channel running |
| burst_sts | output | 1 | Burst in progress |
| xfer_sts | output | 1 | Transfer in progress |
| trig_flag | output | 1 | Latched trigger pending |
| ovf_flag | output | 1 | Trigger overflow error |
| ch_int | output | 1 | Channel interrupt pulse |

## Verification
The bench builds the sequencer with a burst limit of 4 words and a transfer limit of 4 bursts, so each counter is only 2 bits wide. With counters that small, the bench can sweep every burst length, every transfer length, both chaining modes and both interrupt timings, and can also alternate between a free-flowing and a stalling datapath. Each case compares the number of handshakes against the product of the two lengths, and checks where the interrupt lands relative to the transfer status. Separate scenarios cover halt and resume under back-pressure, continuous restart, overflow with its interrupt gating, and the trigger enable.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef struct packed {
    logic oneshot;
    logic contin;
    logic int_at_end;
    logic int_en;
    logic ovr_int_en;
  } chan_mode_t;

  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dma_trig_latch.sv
module dma_trig_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sreset,
  input  logic trig_en,
  input  logic periph_trig,
  input  logic force_trig,
  input  logic clr_flag,
  input  logic clr_err,
  input  logic consume,
  output logic flag,
  output logic ovf,
  output logic ovr_evt
);
  logic ev;

  assign ev      = trig_en & (periph_trig | force_trig);
  assign ovr_evt = ev & flag & ~consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ovf  <= 1'b0;
    end else if (sreset) begin
      flag <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (ev)                      flag <= 1'b1;
      else if (consume | clr_flag) flag <= 1'b0;
      if (ovr_evt)      ovf <= 1'b1;
      else if (clr_err) ovf <= 1'b0;
    end
  end

  // R2: with triggering disabled the flag cannot rise
  p_flag_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !trig_en) |=> !flag);

  // R4: overflow is sticky until the error clear
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_err && !sreset) |=> ovf);

endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
  parameter int BW = 5,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sreset,
  input  logic          burst_load,
  input  logic [BW-1:0] burst_len,
  input  logic          xfer_load,
  input  logic [TW-1:0] xfer_len,
  input  logic          word_done,
  output logic          burst_last,
  output logic          xfer_last
);
  logic [BW-1:0] bcnt;
  logic [TW-1:0] tcnt;

  assign burst_last = (bcnt == '0);
  assign xfer_last  = (tcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      tcnt <= '0;
    end else if (sreset) begin
      bcnt <= '0;
      tcnt <= '0;
    end else begin
      if (burst_load)                    bcnt <= burst_len;
      else if (word_done && !burst_last) bcnt <= bcnt - 1'b1;
      if (xfer_load)                                   tcnt <= xfer_len;
      else if (word_done && burst_last && !xfer_last)  tcnt <= tcnt - 1'b1;
    end
  end

  // R11: with no load and no completed word the burst count holds (halt keeps state)
  p_bcnt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_load && !word_done && !sreset) |=> $stable(bcnt));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int MAX_BURST = 32,
  parameter int MAX_XFER  = 65536,
  localparam int BW = cnt_w(MAX_BURST),
  localparam int TW = cnt_w(MAX_XFER)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          run,
  input  logic          halt,
  input  logic          force_trig,
  input  logic          clr_trig,
  input  logic          clr_err,
  input  logic          periph_trig,
  input  logic          trig_en,
  input  logic          oneshot,
  input  logic          contin,
  input  logic          int_at_end,
  input  logic          int_en,
  input  logic          ovr_int_en,
  input  logic [BW-1:0] burst_len,
  input  logic [TW-1:0] xfer_len,
  output logic          word_valid,
  input  logic          word_ready,
  output logic          run_sts,
  output logic          burst_sts,
  output logic          xfer_sts,
  output logic          trig_flag,
  output logic          ovf_flag,
  output logic          ch_int
);
  chan_mode_t mode;
  logic running, in_burst, in_xfer, halt_pend, int_q;
  logic word_done, stop_now, chain, burst_go, consume;
  logic burst_last, xfer_last, burst_end, xfer_end, xfer_begin, xfer_load;
  logic ovr_evt;

  assign mode = '{oneshot: oneshot, contin: contin, int_at_end: int_at_end,
                  int_en: int_en, ovr_int_en: ovr_int_en};

  assign word_valid = running & in_burst;
  assign word_done  = word_valid & word_ready;
  // a halt waits while a word is offered but not yet accepted
  assign stop_now   = (halt | halt_pend) & ~(word_valid & ~word_ready);
  assign chain      = mode.oneshot & in_xfer;
  assign burst_go   = running & ~stop_now & ~in_burst & (trig_flag | chain) & ~soft_rst;
  assign consume    = burst_go & ~chain;
  assign burst_end  = word_done & burst_last;
  assign xfer_end   = burst_end & xfer_last;
  assign xfer_begin = burst_go & ~in_xfer;
  assign xfer_load  = (run & ~in_xfer) | xfer_end;

  dma_trig_latch u_trig (
    .clk(clk), .rst_n(rst_n), .sreset(soft_rst),
    .trig_en(trig_en), .periph_trig(periph_trig), .force_trig(force_trig),
    .clr_flag(clr_trig), .clr_err(clr_err), .consume(consume),
    .flag(trig_flag), .ovf(ovf_flag), .ovr_evt(ovr_evt)
  );

  dma_cnt_unit #(.BW(BW), .TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sreset(soft_rst),
    .burst_load(burst_go), .burst_len(burst_len),
    .xfer_load(xfer_load), .xfer_len(xfer_len),
    .word_done(word_done), .burst_last(burst_last), .xfer_last(xfer_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; in_burst <= 1'b0; in_xfer <= 1'b0;
      halt_pend <= 1'b0; int_q <= 1'b0;
    end else if (soft_rst) begin
      running <= 1'b0; in_burst <= 1'b0; in_xfer <= 1'b0;
      halt_pend <= 1'b0; int_q <= 1'b0;
    end else begin
      if (run)                          running <= 1'b1;
      else if (stop_now)                running <= 1'b0;
      else if (xfer_end && !mode.contin) running <= 1'b0;

      if (run || stop_now) halt_pend <= 1'b0;
      else if (halt)       halt_pend <= 1'b1;

      if (burst_go)       in_burst <= 1'b1;
      else if (burst_end) in_burst <= 1'b0;

      if (xfer_begin)    in_xfer <= 1'b1;
      else if (xfer_end) in_xfer <= 1'b0;

      int_q <= mode.int_en & ((xfer_begin & ~mode.int_at_end) |
                              (xfer_end & mode.int_at_end) |
                              (ovr_evt & mode.ovr_int_en));
    end
  end

  assign run_sts   = running;
  assign burst_sts = in_burst;
  assign xfer_sts  = in_xfer;
  assign ch_int    = int_q;

  // R12: an offered word is held until accepted
  p_valid_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && !soft_rst) |=> word_valid);

  // R8: a burst only exists inside a transfer
  p_burst_in_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_sts |-> xfer_sts);

  // R7: finishing a transfer without restart stops the channel
  p_stop_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(xfer_sts) && !$past(contin) && !$past(run)) |-> !run_sts);

  // R9: interrupts need the channel enable
  p_int_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !soft_rst) |=> !ch_int);

  // R11: nothing is requested while halted
  p_no_req_halted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_sts |-> !word_valid);

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int MB = 4;
  localparam int MX = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, soft_rst, run, halt, force_trig, clr_trig, clr_err, periph_trig;
  logic trig_en, oneshot, contin, int_at_end, int_en, ovr_int_en;
  logic [1:0] burst_len, xfer_len;
  logic word_valid, word_ready, run_sts, burst_sts, xfer_sts, trig_flag, ovf_flag, ch_int;
  logic stall;

  int errs = 0, checks = 0, words = 0, ints = 0;
  logic int_xs = 1'b0;

  dma_chan_seq #(.MAX_BURST(MB), .MAX_XFER(MX)) u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run), .halt(halt),
    .force_trig(force_trig), .clr_trig(clr_trig), .clr_err(clr_err),
    .periph_trig(periph_trig), .trig_en(trig_en), .oneshot(oneshot),
    .contin(contin), .int_at_end(int_at_end), .int_en(int_en),
    .ovr_int_en(ovr_int_en), .burst_len(burst_len), .xfer_len(xfer_len),
    .word_valid(word_valid), .word_ready(word_ready), .run_sts(run_sts),
    .burst_sts(burst_sts), .xfer_sts(xfer_sts), .trig_flag(trig_flag),
    .ovf_flag(ovf_flag), .ch_int(ch_int)
  );

  always @(posedge clk) word_ready <= stall ? ~word_ready : 1'b1;

  always @(negedge clk) begin
    if (word_valid && word_ready) words++;
    if (ch_int) begin ints++; int_xs = xfer_sts; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 run, 1 halt, 2 periph, 3 force, 4 clr_trig, 5 clr_err, 6 soft_rst
  task automatic strobe(input int k);
    @(negedge clk);
    case (k)
      0: run = 1; 1: halt = 1; 2: periph_trig = 1; 3: force_trig = 1;
      4: clr_trig = 1; 5: clr_err = 1; default: soft_rst = 1;
    endcase
    @(negedge clk);
    run = 0; halt = 0; periph_trig = 0; force_trig = 0;
    clr_trig = 0; clr_err = 0; soft_rst = 0;
  endtask

  task automatic fresh();
    strobe(6);
    words = 0; ints = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int w1;
    rst_n = 0; soft_rst = 0; run = 0; halt = 0; force_trig = 0; clr_trig = 0;
    clr_err = 0; periph_trig = 0; trig_en = 1; oneshot = 0; contin = 0;
    int_at_end = 0; int_en = 1; ovr_int_en = 0; burst_len = 0; xfer_len = 0;
    stall = 0; word_ready = 1;
    tick(3); rst_n = 1; tick(1);
    chk("R1 reset status", {run_sts, burst_sts, xfer_sts, trig_flag, ovf_flag, ch_int, word_valid}, 0);

    // R13: trigger while stopped only latches
    words = 0;
    strobe(2); tick(10);
    chk("R13 flag while stopped", trig_flag, 1);
    chk("R13 no words while stopped", words, 0);
    chk("R13 no transfer while stopped", xfer_sts, 0);

    // R3: clear strobe
    strobe(4); tick(1);
    chk("R3 clear trigger flag", trig_flag, 0);

    // R2: enable gates both sources
    fresh(); trig_en = 0;
    strobe(2); strobe(3); tick(1);
    chk("R2 triggers blocked", trig_flag, 0);
    trig_en = 1;
    strobe(3); tick(1);
    chk("R2 force sets flag", trig_flag, 1);

    // R4 / R10: overflow with interrupt
    ovr_int_en = 1; int_en = 1; ints = 0;
    strobe(2); tick(2);
    chk("R4 overflow set", ovf_flag, 1);
    chk("R10 overflow interrupt", ints, 1);
    tick(5);
    chk("R4 overflow sticky", ovf_flag, 1);
    strobe(5); tick(1);
    chk("R4 error clear", ovf_flag, 0);
    int_en = 0; ints = 0;
    strobe(2); tick(2);
    chk("R10 overflow gated by int_en", ints, 0);
    chk("R4 second overflow", ovf_flag, 1);
    ovr_int_en = 0; int_en = 1;

    // R5/R6/R8/R9 sweep
    for (int l = 1; l <= MB; l++)
      for (int t = 1; t <= MX; t++)
        for (int os = 0; os < 2; os++)
          for (int ie = 0; ie < 2; ie++) begin
            fresh();
            stall = ((l + t + ie) % 2) == 1;
            burst_len = 2'(l - 1); xfer_len = 2'(t - 1);
            oneshot = os[0]; int_at_end = ie[0]; contin = 0; int_en = 1;
            strobe(0); tick(1);
            chk("R13 run starts", run_sts, 1);
            if (os == 1) begin
              strobe(2); tick(2 * l * t + t + 10);
            end else begin
              for (int b = 0; b < t; b++) begin
                strobe(2); tick(2 * l + 6);
                chk("R5 one burst per trigger", words, l * (b + 1));
                if (b < t - 1) begin
                  chk("R8 burst status cleared", burst_sts, 0);
                  chk("R8 transfer status held", xfer_sts, 1);
                end
              end
            end
            chk(os ? "R6 chained total" : "R5 total words", words, l * t);
            chk("R9 one interrupt", ints, 1);
            chk("R9 interrupt timing", int_xs, ie ? 0 : 1);
            chk("R7 run cleared", run_sts, 0);
            chk("R8 status cleared", {burst_sts, xfer_sts}, 0);
            chk("R3 flag consumed", trig_flag, 0);
          end

    // R9: disabled interrupt
    fresh(); stall = 0; int_en = 0; oneshot = 1; burst_len = 1; xfer_len = 1;
    strobe(0); strobe(2); tick(20);
    chk("R9 no interrupt when disabled", ints, 0);
    chk("R6 words with int off", words, 4);
    int_en = 1;

    // R7: continuous restart
    fresh(); contin = 1;
    strobe(0); strobe(2); tick(15);
    chk("R7 continuous words", words, 4);
    chk("R7 continuous run held", run_sts, 1);
    chk("R7 continuous waits", xfer_sts, 0);
    tick(10);
    chk("R7 no words without trigger", words, 4);
    strobe(2); tick(15);
    chk("R7 reloaded transfer", words, 8);
    contin = 0;

    // R11/R12: halt and resume under back-pressure
    fresh(); stall = 1; burst_len = 3; xfer_len = 3; oneshot = 1;
    strobe(0); strobe(2); tick(7);
    strobe(1); tick(3);
    w1 = words;
    chk("R11 halt clears run", run_sts, 0);
    chk("R11 transfer state kept", xfer_sts, 1);
    tick(12);
    chk("R11 no words while halted", words, w1);
    chk("R11 partial count", (w1 < 16) ? 1 : 0, 1);
    strobe(0); tick(50);
    chk("R11 resume completes", words, 16);
    chk("R12 total under stall", run_sts, 0);

    // R1: soft reset mid-transfer
    fresh(); stall = 0;
    strobe(0); strobe(2); tick(4);
    strobe(6); tick(1);
    chk("R1 soft reset clears", {run_sts, burst_sts, xfer_sts, trig_flag, ovf_flag, ch_int, word_valid}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule